// File: doc/BRIEF.md
# Counter Access Port with Width Aliasing

This block is the register access front end of a bank of event counters. It has one request port. Each request either writes a general-purpose counter through one of two aliases, writes a fixed counter, or reads any counter through a packed read index. The counting logic is outside its scope. The counters are held here as a plain register array, so that every access rule can be seen at the ports.

The two general-purpose aliases map onto the same storage but shape the written value differently. The legacy alias accepts only the low 32 bits of the data and sign-extends them from bit 31. The full-width alias accepts the whole value, but a value with any bit set above the implemented counter width is refused with a fault. The read index has three fields: a bank selector, a fast-read flag that truncates the result to 32 bits, and a counter number. An index that names a counter which does not exist raises a fault. Every request gets a response exactly one cycle later, carrying a fault flag and the read data.

Top module: `ctr_access_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, all counters, `rsp_vld`, `rsp_fault` and `rsp_data` are cleared to zero, so a read of any counter after reset returns zero.
- R2: A legacy write (`req_op` = 2'b00) to general counter `req_sel` stores bits 31:0 of `req_data` sign-extended from bit 31 and masked to `CTR_W` bits. Bits 63:32 of `req_data` have no effect, and the write never faults when `req_sel` is below `NUM_GP`.
- R3: A full-width write (`req_op` = 2'b01) stores `req_data` masked to `CTR_W` bits. If any bit at position `CTR_W` or above is set, the response faults and the counter keeps its old value.
- R4: Both aliases write the same storage, and a read returns the last accepted value whichever alias wrote it.
- R5: A read (`req_op` = 2'b11) takes `req_sel` as an index. Bit 30 set selects the fixed bank and bit 30 clear selects the general bank. Bits 29:0 are the counter number.
- R6: Bit 31 of the read index requests a fast read. The response then holds bits 31:0 of the counter, with bits 63:32 zero. Without bit 31, the full counter is returned, zero-extended.
- R7: A read whose counter number is not below the count of the selected bank (for example index 64) faults and returns zero data.
- R8: A fixed write (`req_op` = 2'b10) stores `req_data` masked to `CTR_W` bits and never faults on excess bits. A fixed write with `req_sel` not below `NUM_FX` faults.
- R9: A general write with `req_sel` not below `NUM_GP` faults, and no counter changes.
- R10: `rsp_vld` is high in exactly the cycle after a cycle with `req_vld` high. A faulting response carries zero data, and a write response carries zero data.
- R11: With parameter `FULL_WR_EN` = 0, every full-width write faults and leaves the counter unchanged, while legacy writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 00 legacy write, 01 full-width write, 10 fixed write, 11 read |
| req_sel | input | 32 | Counter number for writes, packed read index for reads |
| req_data | input | 64 | Write data |
| rsp_vld | output | 1 | Response valid, one cycle after the strobe |
| rsp_fault | output | 1 | Request refused; no counter was updated |
| rsp_data | output | 64 | Read data; zero for writes and faults |

## Verification
Every general counter is written through the legacy alias with patterns chosen to separate correct behaviour from likely faults:
- a positive low word;
- a low word with bit 31 set, which exposes a missing sign extension;
- a value with junk in the upper half, which exposes a failure to discard bits 63:32.

Each counter is then read both in full and through the fast index, which separates correct truncation from a full return. Full-width writes are tried both at the width limit and one bit above it; the second must fault and leave the old value readable. Fixed writes carry excess bits that must be masked without a fault. Distinct values are placed in matching slots of the two banks to show that the bank bit really selects. Out-of-range numbers in both banks, including 64, must fault with zero data. A second instance with full-width writes disabled shows that the same request is refused.

// File: rtl/cap_pkg.sv
// Shared definitions for the counter access port.
// Assumes a 64-bit data bus and a 32-bit read index word.
package cap_pkg;
    localparam int unsigned BUS_W    = 64;
    localparam int unsigned IDX_W    = 32;
    localparam int unsigned FAST_BIT = 31;
    localparam int unsigned BANK_BIT = 30;
    localparam int unsigned NUM_W    = 30;

    typedef enum logic [1:0] {
        OP_WR_LEGACY = 2'b00,
        OP_WR_FULL   = 2'b01,
        OP_WR_FIXED  = 2'b10,
        OP_READ      = 2'b11
    } cap_op_e;
endpackage

// File: rtl/cap_wshape.sv
// Write value shaping: sign-extends legacy data, masks full-width and fixed
// data, and flags a full-width write that cannot be accepted.
// Assumes 1 <= CTR_W <= 64. Purely combinational.
module cap_wshape #(
    parameter int unsigned CTR_W      = 48,
    parameter bit          FULL_WR_EN = 1'b1
) (
    input  logic [cap_pkg::BUS_W-1:0] din,
    input  cap_pkg::cap_op_e          op,
    output logic [CTR_W-1:0]          shaped,
    output logic                      width_fault
);
    import cap_pkg::*;

    logic [BUS_W-1:0] sext;
    logic             excess;

    // Sign-extend the low word to the bus width.
    always_comb sext = {{(BUS_W-32){din[31]}}, din[31:0]};

    // Any bit at or above the counter width is excess.
    always_comb excess = ((din >> CTR_W) != '0);

    // Pick the shaped value for the requested alias.
    always_comb begin
        if (op == OP_WR_LEGACY) shaped = sext[CTR_W-1:0];
        else                    shaped = din[CTR_W-1:0];
    end

    // A full-width write faults on excess bits or when the alias is disabled.
    always_comb width_fault = (op == OP_WR_FULL) && (!FULL_WR_EN || excess);
endmodule

// File: rtl/cap_ridx.sv
// Read index decoder: splits the index into bank, fast flag and counter
// number, and flags numbers that fall outside the selected bank.
// Assumes NUM_GP and NUM_FX are at least 1. Purely combinational.
module cap_ridx #(
    parameter int unsigned NUM_GP = 4,
    parameter int unsigned NUM_FX = 3,
    parameter int unsigned SEL_W  = 2
) (
    input  logic [cap_pkg::IDX_W-1:0] idx,
    output logic                      fixed_sel,
    output logic                      fast,
    output logic [SEL_W-1:0]          num,
    output logic                      range_fault
);
    import cap_pkg::*;

    logic [NUM_W-1:0] full_num;

    // Field extraction.
    always_comb begin
        fixed_sel = idx[BANK_BIT];
        fast      = idx[FAST_BIT];
        full_num  = idx[NUM_W-1:0];
        num       = full_num[SEL_W-1:0];
    end

    // Bounds check against the bank that was selected.
    always_comb begin
        if (fixed_sel) range_fault = (full_num >= NUM_W'(NUM_FX));
        else           range_fault = (full_num >= NUM_W'(NUM_GP));
    end
endmodule

// File: rtl/cap_bank.sv
// Counter storage bank: N registers with one write port and one read port.
// Assumes wr_sel < N whenever wr_en is high. An out-of-range rd_sel reads zero.
module cap_bank #(
    parameter int unsigned N     = 4,
    parameter int unsigned CTR_W = 48,
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CTR_W-1:0] wr_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [CTR_W-1:0] rd_val
);
    logic [CTR_W-1:0] q [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_ctr
        // Hold or load one counter.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    q[gi] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(gi)))      q[gi] <= wr_val;
        end

        // R3 / R9 / R11: a counter not addressed by an accepted write keeps its value.
        a_r9_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SEL_W'(gi))) |=> $stable(q[gi]));
    end

    // Read multiplexer.
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < N; k++)
            if (rd_sel == SEL_W'(k)) rd_val = q[k];
    end
endmodule

// File: rtl/ctr_access_port.sv
// Counter access port: decodes requests, shapes write data, stores counters in
// two banks and returns a registered response one cycle after each strobe.
// Assumes one request per strobe cycle and CTR_W in 1..64.
module ctr_access_port #(
    parameter int unsigned CTR_W      = 48,
    parameter int unsigned NUM_GP     = 4,
    parameter int unsigned NUM_FX     = 3,
    parameter bit          FULL_WR_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_vld,
    input  logic [1:0]  req_op,
    input  logic [31:0] req_sel,
    input  logic [63:0] req_data,
    output logic        rsp_vld,
    output logic        rsp_fault,
    output logic [63:0] rsp_data
);
    import cap_pkg::*;

    localparam int unsigned MAX_N = (NUM_GP > NUM_FX) ? NUM_GP : NUM_FX;
    localparam int unsigned SEL_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    cap_op_e          op;
    logic [CTR_W-1:0] shaped;
    logic             width_fault;
    logic             rd_fixed, rd_fast, rd_range_fault;
    logic [SEL_W-1:0] rd_num;
    logic             gp_sel_ok, fx_sel_ok;
    logic             gp_wr_en, fx_wr_en;
    logic [CTR_W-1:0] gp_rd, fx_rd;
    logic             fault_nxt;
    logic [BUS_W-1:0] data_nxt, full_rd;

    // Operation decode.
    always_comb op = cap_op_e'(req_op);

    cap_wshape #(.CTR_W(CTR_W), .FULL_WR_EN(FULL_WR_EN)) u_wshape (
        .din(req_data), .op(op), .shaped(shaped), .width_fault(width_fault));

    cap_ridx #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .SEL_W(SEL_W)) u_ridx (
        .idx(req_sel), .fixed_sel(rd_fixed), .fast(rd_fast),
        .num(rd_num), .range_fault(rd_range_fault));

    // Write target bounds check.
    always_comb begin
        gp_sel_ok = (req_sel < 32'(NUM_GP));
        fx_sel_ok = (req_sel < 32'(NUM_FX));
    end

    // Write enables: only accepted writes reach the banks.
    always_comb begin
        gp_wr_en = req_vld && (op == OP_WR_LEGACY || op == OP_WR_FULL) && gp_sel_ok && !width_fault;
        fx_wr_en = req_vld && (op == OP_WR_FIXED) && fx_sel_ok;
    end

    cap_bank #(.N(NUM_GP), .CTR_W(CTR_W), .SEL_W(SEL_W)) u_gp_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(gp_wr_en), .wr_sel(req_sel[SEL_W-1:0]),
        .wr_val(shaped), .rd_sel(rd_num), .rd_val(gp_rd));

    cap_bank #(.N(NUM_FX), .CTR_W(CTR_W), .SEL_W(SEL_W)) u_fx_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(fx_wr_en), .wr_sel(req_sel[SEL_W-1:0]),
        .wr_val(shaped), .rd_sel(rd_num), .rd_val(fx_rd));

    // Select bank output and zero-extend.
    always_comb full_rd = BUS_W'(rd_fixed ? fx_rd : gp_rd);

    // Fault and data for the response.
    always_comb begin
        fault_nxt = 1'b0;
        data_nxt  = '0;
        case (op)
            OP_WR_LEGACY: fault_nxt = !gp_sel_ok;
            OP_WR_FULL:   fault_nxt = !gp_sel_ok || width_fault;
            OP_WR_FIXED:  fault_nxt = !fx_sel_ok;
            default: begin
                fault_nxt = rd_range_fault;
                if (!rd_range_fault)
                    data_nxt = rd_fast ? {32'b0, full_rd[31:0]} : full_rd;
            end
        endcase
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_vld   <= req_vld;
            rsp_fault <= req_vld && fault_nxt;
            rsp_data  <= req_vld ? data_nxt : '0;
        end
    end

    // R10: response valid tracks the strobe with one cycle of delay.
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    a_r10_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);
    // R10: a faulting response carries no data.
    a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_fault) |-> (rsp_data == '0));
    // R3: excess bits on a full-width write always fault.
    a_r3_excess_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && op == OP_WR_FULL && ((req_data >> CTR_W) != '0)) |=> rsp_fault);
    // R2: an in-range legacy write is never refused.
    a_r2_legacy_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && op == OP_WR_LEGACY && req_sel < 32'(NUM_GP)) |=> !rsp_fault);
    // R6: a fast read never returns upper bits.
    a_r6_fast_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && op == OP_READ && req_sel[FAST_BIT]) |=> (rsp_data[63:32] == '0));

    if (!FULL_WR_EN) begin : g_nofull_chk
        // R11: the disabled alias refuses every write.
        a_r11_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld && op == OP_WR_FULL) |=> rsp_fault);
    end
endmodule

// File: tb/ctr_access_port_bench.sv
module ctr_access_port_bench;
    localparam int CW = 48;
    localparam int NG = 4;
    localparam int NF = 3;
    localparam logic [63:0] MASK = (64'd1 << CW) - 64'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_a = 1'b0, vld_b = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] sel = '0;
    logic [63:0] wd = '0;
    logic        rv_a, rf_a, rv_b, rf_b;
    logic [63:0] rd_a, rd_b;

    logic        r_vld, r_fault;
    logic [63:0] r_data;
    int          total = 0, bad = 0;
    logic [63:0] gp_m [NG];
    logic [63:0] fx_m [NF];
    logic [63:0] pats [5];

    always #10 clk = ~clk;

    ctr_access_port #(.CTR_W(CW), .NUM_GP(NG), .NUM_FX(NF), .FULL_WR_EN(1'b1)) u_ctr_access_port (
        .clk(clk), .rst_n(rst_n), .req_vld(vld_a), .req_op(op), .req_sel(sel),
        .req_data(wd), .rsp_vld(rv_a), .rsp_fault(rf_a), .rsp_data(rd_a));

    ctr_access_port #(.CTR_W(CW), .NUM_GP(NG), .NUM_FX(NF), .FULL_WR_EN(1'b0)) u_ctr_access_port_nofw (
        .clk(clk), .rst_n(rst_n), .req_vld(vld_b), .req_op(op), .req_sel(sel),
        .req_data(wd), .rsp_vld(rv_b), .rsp_fault(rf_b), .rsp_data(rd_b));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Issue one request, then sample the response one cycle later.
    task automatic do_req(input bit to_b, input logic [1:0] o, input logic [31:0] s, input logic [63:0] d);
        @(negedge clk);
        op = o; sel = s; wd = d;
        if (to_b) vld_b = 1'b1; else vld_a = 1'b1;
        @(negedge clk);
        vld_a = 1'b0; vld_b = 1'b0;
        r_vld   = to_b ? rv_b : rv_a;
        r_fault = to_b ? rf_b : rf_a;
        r_data  = to_b ? rd_b : rd_a;
    endtask

    function automatic logic [63:0] sext_mask(input logic [63:0] d);
        return {{32{d[31]}}, d[31:0]} & MASK;
    endfunction

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pats[0] = 64'h0000_0000_1234_5678;
        pats[1] = 64'h0000_0000_8000_0001;
        pats[2] = 64'hFFFF_FF01_2345_6789;
        pats[3] = 64'hABCD_0000_FFFF_FFFF;
        pats[4] = 64'h5A5A_A5A5_7FFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs
        chk("R1 rsp_vld", {63'b0, rv_a}, 64'd0);
        chk("R1 rsp_fault", {63'b0, rf_a}, 64'd0);
        chk("R1 rsp_data", rd_a, 64'd0);
        for (int i = 0; i < NG; i++) begin
            do_req(1'b0, 2'b11, 32'(i), '0);
            chk("R1 gp reads zero", r_data, 64'd0);
            gp_m[i] = '0;
        end
        for (int j = 0; j < NF; j++) begin
            do_req(1'b0, 2'b11, 32'h4000_0000 | 32'(j), '0);
            chk("R1 fixed reads zero", r_data, 64'd0);
            fx_m[j] = '0;
        end

        // R2 / R6 / R10: legacy writes over all counters and patterns
        for (int i = 0; i < NG; i++) begin
            for (int p = 0; p < 5; p++) begin
                logic [63:0] d;
                d = pats[p] ^ (64'(i) << 4);
                do_req(1'b0, 2'b00, 32'(i), d);
                chk("R10 write rsp_vld", {63'b0, r_vld}, 64'd1);
                chk("R2 legacy no fault", {63'b0, r_fault}, 64'd0);
                chk("R10 write data zero", r_data, 64'd0);
                gp_m[i] = sext_mask(d);
                @(negedge clk);
                chk("R10 idle rsp_vld low", {63'b0, rv_a}, 64'd0);
                do_req(1'b0, 2'b11, 32'(i), '0);
                chk("R2 legacy readback", r_data, gp_m[i]);
                do_req(1'b0, 2'b11, 32'h8000_0000 | 32'(i), '0);
                chk("R6 fast read low word", r_data, {32'b0, gp_m[i][31:0]});
            end
        end

        // R3 / R4: full-width writes in range, then over range
        for (int i = 0; i < NG; i++) begin
            logic [63:0] d;
            d = (64'hFF01_2345_6789 ^ (64'(i) << 40)) & MASK;
            do_req(1'b0, 2'b01, 32'(i), d);
            chk("R3 full accept", {63'b0, r_fault}, 64'd0);
            gp_m[i] = d;
            do_req(1'b0, 2'b11, 32'(i), '0);
            chk("R4 full readback same storage", r_data, gp_m[i]);
            do_req(1'b0, 2'b01, 32'(i), d | (64'd1 << CW));
            chk("R3 excess faults", {63'b0, r_fault}, 64'd1);
            chk("R10 fault data zero", r_data, 64'd0);
            do_req(1'b0, 2'b01, 32'(i), 64'hFFFF_FF01_2345_6789);
            chk("R3 wide value faults", {63'b0, r_fault}, 64'd1);
            do_req(1'b0, 2'b11, 32'(i), '0);
            chk("R3 counter unchanged", r_data, gp_m[i]);
            do_req(1'b0, 2'b00, 32'(i), 64'h0000_0000_F000_0000);
            gp_m[i] = 64'hFFFF_F000_0000;
            do_req(1'b0, 2'b11, 32'(i), '0);
            chk("R4 legacy overrides full", r_data, gp_m[i]);
        end

        // R8 / R5: fixed bank writes with excess bits
        for (int j = 0; j < NF; j++) begin
            logic [63:0] d;
            d = 64'hFFFF_0123_4567_89AB + 64'(j);
            do_req(1'b0, 2'b10, 32'(j), d);
            chk("R8 fixed no fault", {63'b0, r_fault}, 64'd0);
            fx_m[j] = d & MASK;
            do_req(1'b0, 2'b11, 32'h4000_0000 | 32'(j), '0);
            chk("R8 fixed masked readback", r_data, fx_m[j]);
            do_req(1'b0, 2'b11, 32'hC000_0000 | 32'(j), '0);
            chk("R6 fixed fast read", r_data, {32'b0, fx_m[j][31:0]});
            do_req(1'b0, 2'b11, 32'(j), '0);
            chk("R5 bank bit separates banks", r_data, gp_m[j]);
        end

        // R7: bad read indices
        begin
            logic [31:0] badidx [6];
            badidx[0] = 32'd64; badidx[1] = 32'd4; badidx[2] = 32'h4000_0003;
            badidx[3] = 32'h8000_0004; badidx[4] = 32'h4000_0040; badidx[5] = 32'hC000_0003;
            for (int k = 0; k < 6; k++) begin
                do_req(1'b0, 2'b11, badidx[k], '0);
                chk("R7 bad index faults", {63'b0, r_fault}, 64'd1);
                chk("R7 bad index data zero", r_data, 64'd0);
            end
        end

        // R9 / R8: out-of-range write targets
        do_req(1'b0, 2'b00, 32'd4, 64'h1111);
        chk("R9 legacy bad sel faults", {63'b0, r_fault}, 64'd1);
        do_req(1'b0, 2'b01, 32'd64, 64'h2222);
        chk("R9 full bad sel faults", {63'b0, r_fault}, 64'd1);
        do_req(1'b0, 2'b10, 32'd3, 64'h3333);
        chk("R8 fixed bad sel faults", {63'b0, r_fault}, 64'd1);
        for (int i = 0; i < NG; i++) begin
            do_req(1'b0, 2'b11, 32'(i), '0);
            chk("R9 gp unchanged after bad writes", r_data, gp_m[i]);
        end
        for (int j = 0; j < NF; j++) begin
            do_req(1'b0, 2'b11, 32'h4000_0000 | 32'(j), '0);
            chk("R8 fixed unchanged after bad writes", r_data, fx_m[j]);
        end

        // R11: instance without full-width writes
        for (int i = 0; i < NG; i++) begin
            do_req(1'b1, 2'b01, 32'(i), 64'h0000_0000_0000_0042);
            chk("R11 full write refused", {63'b0, r_fault}, 64'd1);
            do_req(1'b1, 2'b11, 32'(i), '0);
            chk("R11 counter unchanged", r_data, 64'd0);
            do_req(1'b1, 2'b00, 32'(i), 64'h0000_0000_8000_0000);
            chk("R11 legacy still accepted", {63'b0, r_fault}, 64'd0);
            do_req(1'b1, 2'b11, 32'(i), '0);
            chk("R11 legacy readback", r_data, 64'hFFFF_8000_0000);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule